// File: doc/BRIEF.md
# Snooping Bank Expander for a CPU RAM Window

This block sits on the static-RAM bus of an 8-bit processor and drives a larger SRAM behind it. Every ordinary access passes straight through: the chip select and both strobes reach the SRAM combinationally, and the low fifteen address bits are forwarded. So a 32 KB window of the CPU's address map lands in one 32 KB bank of a 512 KB part, with no wait states.

One location of the window, CPU address 0x8000, is watched. While the block is locked, that location behaves like any other RAM byte. When software stores a fixed four-byte key there, in order, the block enters command mode. In command mode, stores to that location pick the bank, or relock the block, and do not reach the SRAM. Loads from that location return a status byte. Software that never writes the key sees a plain 32 KB RAM.

Top module: `sbx_top`

## Requirements
- R1: After reset the block is locked and bank 0 is selected, so SRAM address bits [18:15] are 0 and loads from 0x8000 return SRAM data.
- R2: The SRAM address is {bank[3:0], cpuAddr[14:0]} in every mode.
- R3: Outside command-mode accesses to 0x8000, sramCs equals cpuCs, sramWe equals cpuCs&cpuWr, sramOe equals cpuCs&cpuRd, and cpuRdata equals sramRdata. These relations hold in the same cycle.
- R4: While locked, loads and stores at 0x8000 reach the SRAM like those at any other address, including the stores that make up the key.
- R5: Storing 0xA5, 0x5A, 0xC3, 0x3C to 0x8000, in that order, enters command mode from the cycle after the fourth store. The fourth store still reaches the SRAM.
- R6: A store to 0x8000 of a value other than the next expected key byte returns the matcher to its first state, even if that value is 0xA5.
- R7: Loads, and stores to any other address, neither advance nor reset the matcher, and they do not change the mode.
- R8: In command mode, a store of 0x00–0x0F to 0x8000 selects that bank from the next cycle, with sramWe held low.
- R9: In command mode, a store of 0xFF to 0x8000 relocks the block from the next cycle and keeps the current bank. The store does not reach the SRAM.
- R10: In command mode, a store of any other value to 0x8000 leaves the bank and the mode unchanged and does not reach the SRAM.
- R11: In command mode, a load of 0x8000 returns {1'b1, 3'b000, bank[3:0]} with sramOe held low.
- R12: With cpuCs low, no SRAM strobe is driven and no store is seen by the matcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuCs | input | 1 | CPU RAM chip select, active high |
| cpuRd | input | 1 | CPU read strobe, active high |
| cpuWr | input | 1 | CPU write strobe, active high; a store is taken at the clock edge |
| cpuAddr | input | 16 | CPU address |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Read data returned to the CPU |
| sramAddr | output | 19 | SRAM address |
| sramWdata | output | 8 | SRAM write data |
| sramRdata | input | 8 | SRAM read data |
| sramCs | output | 1 | SRAM chip select, active high |
| sramWe | output | 1 | SRAM write enable, active high |
| sramOe | output | 1 | SRAM output enable, active high |

## Verification
Two functions meet in the same cycle: the store that completes the key is both a plain SRAM store and the event that switches the mode, and the relocking store is both a command and a store that the block must still hold back from the SRAM. The bench provokes both with back-to-back stores to 0x8000. In the cycle of the store it checks the strobes, which must follow the old mode. On the next access it checks the mode, through the status byte or through a load that reaches the SRAM.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
  localparam int CPU_AW   = 16;
  localparam int WIN_AW   = 15;
  localparam int DW       = 8;
  localparam int BANK_W   = 4;
  localparam int SRAM_AW  = WIN_AW + BANK_W;
  localparam int BANK_CNT = 1 << BANK_W;
  localparam int KEY_LEN  = 4;
  localparam int KEY_IDX_W = $clog2(KEY_LEN);
  localparam int STAT_PAD = DW - 1 - BANK_W;
  localparam logic [CPU_AW-1:0] CTRL_ADDR  = 16'h8000;
  localparam logic [DW-1:0]     RELOCK_CODE = 8'hFF;

  typedef struct packed {
    logic              cmdMode;
    logic [BANK_W-1:0] bank;
  } ctrlStrb_t;

  function automatic logic [DW-1:0] keyByte(input logic [KEY_IDX_W-1:0] idx);
    case (idx)
      2'd0:    keyByte = 8'hA5;
      2'd1:    keyByte = 8'h5A;
      2'd2:    keyByte = 8'hC3;
      default: keyByte = 8'h3C;
    endcase
  endfunction
endpackage

// File: rtl/sbx_ctrl.sv
module sbx_ctrl
  import sbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrlWr,
  input  logic [DW-1:0] wrData,
  output ctrlStrb_t     strb
);
  logic [KEY_IDX_W-1:0] keyIdx, keyIdxNxt;
  logic                 cmdMode, cmdModeNxt;
  logic [BANK_W-1:0]    bank, bankNxt;
  logic                 keyHit, keyLast, bankCmd, relockCmd;

  always_comb begin
    keyHit     = (wrData == keyByte(keyIdx));
    keyLast    = (keyIdx == KEY_IDX_W'(KEY_LEN - 1));
    bankCmd    = (wrData < DW'(BANK_CNT));
    relockCmd  = (wrData == RELOCK_CODE);
    keyIdxNxt  = keyIdx;
    cmdModeNxt = cmdMode;
    bankNxt    = bank;
    if (ctrlWr) begin
      if (!cmdMode) begin
        if (keyHit && keyLast) begin
          cmdModeNxt = 1'b1;
          keyIdxNxt  = '0;
        end else if (keyHit) begin
          keyIdxNxt = keyIdx + 1'b1;
        end else begin
          keyIdxNxt = '0;
        end
      end else if (relockCmd) begin
        cmdModeNxt = 1'b0;
        keyIdxNxt  = '0;
      end else if (bankCmd) begin
        bankNxt = wrData[BANK_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      keyIdx  <= '0;
      cmdMode <= 1'b0;
      bank    <= '0;
    end else begin
      keyIdx  <= keyIdxNxt;
      cmdMode <= cmdModeNxt;
      bank    <= bankNxt;
    end
  end

  assign strb.cmdMode = cmdMode;
  assign strb.bank    = bank;
endmodule

// File: rtl/sbx_datapath.sv
module sbx_datapath
  import sbx_pkg::*;
(
  input  logic               cpuCs,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [DW-1:0]      cpuWdata,
  output logic [DW-1:0]      cpuRdata,
  input  ctrlStrb_t          strb,
  output logic               ctrlWr,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DW-1:0]      sramWdata,
  input  logic [DW-1:0]      sramRdata,
  output logic               sramCs,
  output logic               sramWe,
  output logic               sramOe
);
  logic          ctrlHit, intercept;
  logic [DW-1:0] statusByte;

  always_comb begin
    ctrlHit    = (cpuAddr == CTRL_ADDR);
    intercept  = strb.cmdMode && ctrlHit;
    ctrlWr     = cpuCs && cpuWr && ctrlHit;
    statusByte = {strb.cmdMode, {STAT_PAD{1'b0}}, strb.bank};
    sramCs     = cpuCs;
    sramWe     = cpuCs && cpuWr && !intercept;
    sramOe     = cpuCs && cpuRd && !intercept;
    sramAddr   = {strb.bank, cpuAddr[WIN_AW-1:0]};
    sramWdata  = cpuWdata;
    cpuRdata   = intercept ? statusByte : sramRdata;
  end
endmodule

// File: rtl/sbx_top.sv
module sbx_top
  import sbx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cpuCs,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic [DW-1:0]      cpuWdata,
  output logic [DW-1:0]      cpuRdata,
  output logic [SRAM_AW-1:0] sramAddr,
  output logic [DW-1:0]      sramWdata,
  input  logic [DW-1:0]      sramRdata,
  output logic               sramCs,
  output logic               sramWe,
  output logic               sramOe
);
  ctrlStrb_t ctrlStrb;
  logic      ctrlWr;

  sbx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctrlWr(ctrlWr), .wrData(cpuWdata), .strb(ctrlStrb)
  );

  sbx_datapath u_dp (
    .cpuCs(cpuCs), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .strb(ctrlStrb), .ctrlWr(ctrlWr),
    .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata),
    .sramCs(sramCs), .sramWe(sramWe), .sramOe(sramOe)
  );
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker
  import sbx_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cpuCs,
  input logic               cpuRd,
  input logic               cpuWr,
  input logic [CPU_AW-1:0]  cpuAddr,
  input logic [DW-1:0]      cpuWdata,
  input logic [DW-1:0]      cpuRdata,
  input logic [SRAM_AW-1:0] sramAddr,
  input logic               sramWe,
  input logic               sramOe,
  input logic               sramCs,
  input ctrlStrb_t          ctrlStrb
);
  logic ctrlStore;
  assign ctrlStore = cpuCs && cpuWr && (cpuAddr == CTRL_ADDR);

  assert_bank_select_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrlStore && ctrlStrb.cmdMode && cpuWdata < DW'(BANK_CNT))
      |=> (sramAddr[SRAM_AW-1:WIN_AW] == $past(cpuWdata[BANK_W-1:0])));

  assert_cmd_no_store_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrlStore && ctrlStrb.cmdMode) |-> !sramWe);

  assert_relock_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrlStore && ctrlStrb.cmdMode && cpuWdata == RELOCK_CODE)
      |=> (!ctrlStrb.cmdMode && $stable(ctrlStrb.bank)));

  assert_ignored_code_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrlStore && ctrlStrb.cmdMode && cpuWdata >= DW'(BANK_CNT) && cpuWdata != RELOCK_CODE)
      |=> (ctrlStrb.cmdMode && $stable(ctrlStrb.bank)));

  assert_status_read_R11: assert property (@(posedge clk) disable iff (rst)
    (cpuCs && cpuRd && ctrlStrb.cmdMode && cpuAddr == CTRL_ADDR)
      |-> (!sramOe && cpuRdata == {1'b1, {STAT_PAD{1'b0}}, sramAddr[SRAM_AW-1:WIN_AW]}));

  assert_mode_only_on_ctrl_R7: assert property (@(posedge clk) disable iff (rst)
    !ctrlStore |=> $stable(ctrlStrb.cmdMode));

  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
    !cpuCs |-> (!sramCs && !sramWe && !sramOe));
endmodule

bind sbx_top sbx_checker u_chk (
  .clk(clk), .rst(rst), .cpuCs(cpuCs), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
  .sramAddr(sramAddr), .sramWe(sramWe), .sramOe(sramOe), .sramCs(sramCs),
  .ctrlStrb(ctrlStrb)
);

// File: tb/sim_sbx_top.sv
module sim_sbx_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpuCs, cpuRd, cpuWr;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWdata, cpuRdata, sramWdata, sramRdata;
  logic [18:0] sramAddr;
  logic        sramCs, sramWe, sramOe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  // Bench SRAM: read data is a function of the address
  assign sramRdata = sramAddr[7:0] ^ 8'h3C;

  sbx_top u0 (
    .clk(clk), .rst(rst), .cpuCs(cpuCs), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .sramAddr(sramAddr), .sramWdata(sramWdata), .sramRdata(sramRdata),
    .sramCs(sramCs), .sramWe(sramWe), .sramOe(sramOe)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic        rd;
    logic [7:0]  wd;
    logic [18:0] eAddr;
    logic        eWe;
    logic        eOe;
    logic [7:0]  eRd;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{16'h8000, 1'b0, 1'b1, 8'h00, 19'h00000, 1'b0, 1'b1, 8'h3C}, // R4 locked load
    '{16'h8000, 1'b1, 1'b0, 8'hA5, 19'h00000, 1'b1, 1'b0, 8'h00}, // R4 key store
    '{16'h8000, 1'b1, 1'b0, 8'h5A, 19'h00000, 1'b1, 1'b0, 8'h00}, // R5
    '{16'h8000, 1'b1, 1'b0, 8'hC3, 19'h00000, 1'b1, 1'b0, 8'h00}, // R5
    '{16'h8000, 1'b1, 1'b0, 8'h3C, 19'h00000, 1'b1, 1'b0, 8'h00}, // R5 last key byte still stored
    '{16'h8000, 1'b0, 1'b1, 8'h00, 19'h00000, 1'b0, 1'b0, 8'h80}, // R11 status, bank 0
    '{16'h8000, 1'b1, 1'b0, 8'h07, 19'h00000, 1'b0, 1'b0, 8'h00}, // R8 select bank 7
    '{16'h8123, 1'b0, 1'b1, 8'h00, 19'h38123, 1'b0, 1'b1, 8'h1F}, // R2 R3 mapped load
    '{16'h8000, 1'b0, 1'b1, 8'h00, 19'h38000, 1'b0, 1'b0, 8'h87}, // R11
    '{16'h8000, 1'b1, 1'b0, 8'h42, 19'h38000, 1'b0, 1'b0, 8'h00}, // R10 ignored code
    '{16'h8000, 1'b0, 1'b1, 8'h00, 19'h38000, 1'b0, 1'b0, 8'h87}, // R10 unchanged
    '{16'h8000, 1'b1, 1'b0, 8'hFF, 19'h38000, 1'b0, 1'b0, 8'h00}, // R9 relock
    '{16'h8000, 1'b0, 1'b1, 8'h00, 19'h38000, 1'b0, 1'b1, 8'h3C}, // R9 locked, bank kept
    '{16'h8005, 1'b1, 1'b0, 8'hA5, 19'h38005, 1'b1, 1'b0, 8'h00}  // R3 plain store
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample combinational outputs 5 ns later, commit at posedge
  task automatic bus(input logic cs, input logic wr, input logic rd,
                     input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuCs = cs; cpuWr = wr; cpuRd = rd; cpuAddr = a; cpuWdata = d;
    #5;
  endtask

  task automatic idle();
    @(negedge clk);
    cpuCs = 1'b0; cpuWr = 1'b0; cpuRd = 1'b0;
  endtask

  task automatic sendKey();
    bus(1, 1, 0, 16'h8000, 8'hA5);
    bus(1, 1, 0, 16'h8000, 8'h5A);
    bus(1, 1, 0, 16'h8000, 8'hC3);
    bus(1, 1, 0, 16'h8000, 8'h3C);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish();
  end

  initial begin
    rst = 1'b1; cpuCs = 0; cpuRd = 0; cpuWr = 0; cpuAddr = '0; cpuWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(sramOe === 1'b1, "R1 oe", sramOe, 1);
    chk(sramAddr === 19'h0, "R1 addr", sramAddr, 0);
    chk(cpuRdata === 8'h3C, "R1 rdata", cpuRdata, 8'h3C);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      bus(1, VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wd);
      chk(sramAddr === VECS[i].eAddr, $sformatf("vec%0d addr", i), sramAddr, VECS[i].eAddr);
      chk(sramWe === VECS[i].eWe, $sformatf("vec%0d we", i), sramWe, VECS[i].eWe);
      chk(sramOe === VECS[i].eOe, $sformatf("vec%0d oe", i), sramOe, VECS[i].eOe);
      chk(sramCs === 1'b1, $sformatf("vec%0d cs", i), sramCs, 1);
      if (VECS[i].wr) chk(sramWdata === VECS[i].wd, $sformatf("vec%0d wdata", i), sramWdata, VECS[i].wd);
      if (VECS[i].rd) chk(cpuRdata === VECS[i].eRd, $sformatf("vec%0d rdata", i), cpuRdata, VECS[i].eRd);
    end

    // R3 strobes follow within the cycle: both strobes low
    bus(1, 0, 0, 16'h8010, 8'h00);
    chk(!sramWe && !sramOe, "R3 no strobe", {sramWe, sramOe}, 0);

    // R6 wrong byte mid-key, including a repeated 0xA5: stays locked
    bus(1, 1, 0, 16'h8000, 8'hA5);
    bus(1, 1, 0, 16'h8000, 8'hA5);
    bus(1, 1, 0, 16'h8000, 8'h5A);
    bus(1, 1, 0, 16'h8000, 8'hC3);
    bus(1, 1, 0, 16'h8000, 8'h3C);
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(sramOe === 1'b1, "R6 locked after A5 A5 5A C3 3C", sramOe, 1);
    bus(1, 1, 0, 16'h8000, 8'hA5);
    bus(1, 1, 0, 16'h8000, 8'h11);
    bus(1, 1, 0, 16'h8000, 8'h5A);
    bus(1, 1, 0, 16'h8000, 8'hC3);
    bus(1, 1, 0, 16'h8000, 8'h3C);
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(sramOe === 1'b1, "R6 locked after bad byte", sramOe, 1);

    // R7 other traffic interleaved does not disturb matcher
    bus(1, 1, 0, 16'h8000, 8'hA5);
    bus(1, 1, 0, 16'h8001, 8'h00);
    bus(1, 0, 1, 16'h8000, 8'h00);
    bus(1, 1, 0, 16'h8000, 8'h5A);
    bus(1, 1, 0, 16'h9000, 8'h77);
    bus(1, 1, 0, 16'h8000, 8'hC3);
    bus(1, 1, 0, 16'h8000, 8'h3C);
    chk(sramWe === 1'b1, "R5 final key store reaches SRAM", sramWe, 1);
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(cpuRdata === 8'h87 && !sramOe, "R7 unlocked via interleaved key", cpuRdata, 8'h87);

    // R8 bank 15 boundary, R10 just above range
    bus(1, 1, 0, 16'h8000, 8'h0F);
    bus(1, 1, 0, 16'h8000, 8'h10);
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(cpuRdata === 8'h8F, "R8 bank 15 / R10 0x10 ignored", cpuRdata, 8'h8F);
    bus(1, 0, 1, 16'hFFFF, 8'h00);
    chk(sramAddr === 19'h7FFFF, "R2 top of memory", sramAddr, 19'h7FFFF);

    // R12 chip select low: no strobes; relock code not seen
    bus(0, 1, 0, 16'h8000, 8'hFF);
    chk(!sramCs && !sramWe && !sramOe, "R12 no strobes", {sramCs, sramWe, sramOe}, 0);
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(cpuRdata === 8'h8F, "R12 store ignored", cpuRdata, 8'h8F);

    // R1 reset mid-command returns to locked bank 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(sramOe === 1'b1 && sramAddr === 19'h0, "R1 after reset", sramAddr, 0);

    // R12 key with cs low does not unlock
    for (int k = 0; k < 4; k++) begin
      bus(0, 1, 0, 16'h8000, (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hC3 : 8'h3C);
    end
    bus(1, 0, 1, 16'h8000, 8'h00);
    chk(sramOe === 1'b1, "R12 key without cs", sramOe, 1);

    // R9 relock immediately after unlock
    sendKey();
    bus(1, 1, 0, 16'h8000, 8'hFF);
    chk(sramWe === 1'b0, "R9 relock store held back", sramWe, 0);
    bus(1, 1, 0, 16'h8000, 8'h05);
    chk(sramWe === 1'b1, "R9 locked store passes", sramWe, 1);

    idle();
    finish();
  end
endmodule